// File: doc/BRIEF.md
# Interval Timer and Interrupt Controller

This block combines two 16-bit down-counters with an interrupt flag and enable pair behind a byte-wide register interface addressed by a 4-bit index. The first counter runs continuously. Each time it passes through its terminal state it reloads from a 16-bit latch. In continuous mode it raises an interrupt flag whenever the count reaches zero. The second counter is a one-shot. It is started by a write, and it flags the first time the count reaches zero after that write.

Both counters advance only on a tick-enable pulse from an outside prescaler. Software works the block through register reads and writes, and some of those reads and writes clear flags as a side effect. A shift-transfer engine elsewhere reports its events on a pulse input, which sets a third flag. A single interrupt output combines the enabled shift flag and the enabled timer-1 flag.

Top module: `vtm_timer_intc`

## Requirements
- R1: After reset, the timer-1 latch and counter both hold 0xFFFF. The timer-2 counter holds 0xFFFF and its stored low byte is 0. The auxiliary control register, the flag register and the enable register are all 0, and `irq` is low.
- R2: A write to index 4 or index 6 replaces the low byte of the timer-1 latch. A write to index 5 replaces the high byte of the latch, clears the timer-1 flag, and loads the counter with the whole new latch value.
- R3: A write to index 7 replaces the high byte of the latch and clears the timer-1 flag. It does not load the counter.
- R4: On each tick, timer 1 steps down by one. The tick after the count has wrapped to 0xFFFF reloads the latch instead, so one full period lasts latch+2 ticks. Reads of index 4 and 5 return the counter's low and high byte. Reads of index 6 and 7 return the latch's low and high byte.
- R5: The timer-1 flag (flag bit 6) is set on the tick that brings the count to zero, and only when bits 7:6 of the auxiliary control register (index 11, read and write) equal 01.
- R6: A read of index 4 with `rd_en` high clears the timer-1 flag. A read of index 5 leaves the flag as it is.
- R7: A write to index 8 stores the timer-2 low byte and loads the counter with that byte, zero-extended. A write to index 9 loads the counter with {written byte, stored low byte}. Either write arms a one-shot: the next time the count reaches zero, flag bit 5 is set once. A read of index 8 with `rd_en` high clears bit 5. Reads of index 8 and 9 return the counter's low and high byte.
- R8: A read of the flag register (index 13) returns flags in bits 6:0. Bit 7 is 1 when any flag is also enabled. A write to index 13 clears every flag bit written as 1.
- R9: A write to the enable register (index 14) with bit 7 = 1 sets the enable bits written as 1 in bits 6:0. With bit 7 = 0 it clears them. A read of index 14 always returns bit 7 = 1.
- R10: `irq` is high exactly when flag bit 2 or flag bit 6 is set and also enabled. The timer-2 flag never drives `irq`.
- R11: A `sr_event` pulse sets flag bit 2. A flag set in the same cycle as a clear of that flag wins over the clear.
- R12: The counters change only in cycles with `tick_en` high. A load by register write in the same cycle as a tick takes the written value and ignores the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescaled count-enable pulse |
| sr_event | input | 1 | Shift-transfer event, sets flag bit 2 |
| reg_idx | input | 4 | Register index |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; applies read side effects |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from `reg_idx` |
| irq | output | 1 | Interrupt request |

## Verification
Every register update, counter step and flag change shows up after the single clock edge that samples the write, read strobe, tick or event. `irq` and `rd_data` decode the registers combinationally, so both reflect that edge at once. The bench drives inputs on the falling edge, which puts every stimulus ahead of exactly one rising edge. It samples results shortly after the next falling edge, half a period after the edge that produced them. Register values are observed by changing `reg_idx` with `rd_en` low, so an observation never triggers a read side effect.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int IDX_W  = 4;
    localparam int FLG_W  = DATA_W - 1;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [FLG_W-1:0]  flg_t;

    localparam cnt_t CNT_ONES = '1;

    // register indices (behavioural map)
    localparam logic [IDX_W-1:0] IX_T1_CLO = 4'd4;
    localparam logic [IDX_W-1:0] IX_T1_CHI = 4'd5;
    localparam logic [IDX_W-1:0] IX_T1_LLO = 4'd6;
    localparam logic [IDX_W-1:0] IX_T1_LHI = 4'd7;
    localparam logic [IDX_W-1:0] IX_T2_LO  = 4'd8;
    localparam logic [IDX_W-1:0] IX_T2_HI  = 4'd9;
    localparam logic [IDX_W-1:0] IX_AUX    = 4'd11;
    localparam logic [IDX_W-1:0] IX_FLAG   = 4'd13;
    localparam logic [IDX_W-1:0] IX_ENA    = 4'd14;

    // flag bit positions
    localparam int FB_SR = 2;
    localparam int FB_T2 = 5;
    localparam int FB_T1 = 6;
    localparam int SET_SEL = DATA_W - 1;

    localparam logic [1:0] T1_CONTINUOUS = 2'b01;

    localparam flg_t IRQ_MASK = flg_t'((1 << FB_SR) | (1 << FB_T1));

    typedef struct packed {
        logic t1_lat_lo;
        logic t1_hi_load;
        logic t1_hi_only;
        logic t2_lo_wr;
        logic t2_hi_wr;
        logic aux_wr;
        logic flag_wr;
        logic ena_wr;
        logic t1_rd_clr;
        logic t2_rd_clr;
    } strobe_t;

    typedef struct packed {
        cnt_t  t1_cnt;
        cnt_t  t1_lat;
        cnt_t  t2_cnt;
        byte_t aux;
        flg_t  flags;
        flg_t  ena;
    } view_t;

    function automatic cnt_t t1_step(cnt_t c, cnt_t l);
        return (c == CNT_ONES) ? l : c - cnt_t'(1);
    endfunction
endpackage

// File: rtl/vtm_regif.sv
module vtm_regif
    import vtm_pkg::*;
(
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] reg_idx,
    input  view_t            view,
    output strobe_t          strb,
    output byte_t            rd_data
);
    always_comb begin
        strb            = '0;
        strb.t1_lat_lo  = wr_en && (reg_idx == IX_T1_CLO || reg_idx == IX_T1_LLO);
        strb.t1_hi_load = wr_en && (reg_idx == IX_T1_CHI);
        strb.t1_hi_only = wr_en && (reg_idx == IX_T1_LHI);
        strb.t2_lo_wr   = wr_en && (reg_idx == IX_T2_LO);
        strb.t2_hi_wr   = wr_en && (reg_idx == IX_T2_HI);
        strb.aux_wr     = wr_en && (reg_idx == IX_AUX);
        strb.flag_wr    = wr_en && (reg_idx == IX_FLAG);
        strb.ena_wr     = wr_en && (reg_idx == IX_ENA);
        strb.t1_rd_clr  = rd_en && (reg_idx == IX_T1_CLO);
        strb.t2_rd_clr  = rd_en && (reg_idx == IX_T2_LO);
    end

    logic pending;
    assign pending = |(view.flags & view.ena);

    always_comb begin
        case (reg_idx)
            IX_T1_CLO: rd_data = view.t1_cnt[DATA_W-1:0];
            IX_T1_CHI: rd_data = view.t1_cnt[CNT_W-1:DATA_W];
            IX_T1_LLO: rd_data = view.t1_lat[DATA_W-1:0];
            IX_T1_LHI: rd_data = view.t1_lat[CNT_W-1:DATA_W];
            IX_T2_LO:  rd_data = view.t2_cnt[DATA_W-1:0];
            IX_T2_HI:  rd_data = view.t2_cnt[CNT_W-1:DATA_W];
            IX_AUX:    rd_data = view.aux;
            IX_FLAG:   rd_data = {pending, view.flags};
            IX_ENA:    rd_data = {1'b1, view.ena};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/vtm_timer1.sv
module vtm_timer1
    import vtm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_en,
    input  logic  cont_mode,
    input  logic  lat_lo_wr,
    input  logic  hi_load,
    input  logic  hi_only,
    input  byte_t wr_data,
    output cnt_t  cnt,
    output cnt_t  latch,
    output logic  zero_evt
);
    cnt_t stepped;
    assign stepped  = t1_step(cnt, latch);
    assign zero_evt = tick_en && !hi_load && cont_mode && (stepped == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= CNT_ONES;
            latch <= CNT_ONES;
        end else begin
            if (lat_lo_wr)
                latch[DATA_W-1:0] <= wr_data;
            if (hi_load || hi_only)
                latch[CNT_W-1:DATA_W] <= wr_data;
            if (hi_load)
                cnt <= {wr_data, latch[DATA_W-1:0]};
            else if (tick_en)
                cnt <= stepped;
        end
    end
endmodule

// File: rtl/vtm_timer2.sv
module vtm_timer2
    import vtm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_en,
    input  logic  lo_wr,
    input  logic  hi_wr,
    input  byte_t wr_data,
    output cnt_t  cnt,
    output logic  zero_evt
);
    byte_t lo_q;
    logic  armed;
    cnt_t  dec;
    logic  load;

    assign dec      = cnt - cnt_t'(1);
    assign load     = lo_wr || hi_wr;
    assign zero_evt = tick_en && !load && armed && (dec == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= CNT_ONES;
            lo_q  <= '0;
            armed <= 1'b0;
        end else if (lo_wr) begin
            lo_q  <= wr_data;
            cnt   <= cnt_t'(wr_data);
            armed <= 1'b1;
        end else if (hi_wr) begin
            cnt   <= {wr_data, lo_q};
            armed <= 1'b1;
        end else if (tick_en) begin
            cnt <= dec;
            if (zero_evt)
                armed <= 1'b0;
        end
    end
endmodule

// File: rtl/vtm_intc.sv
module vtm_intc
    import vtm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strb,
    input  byte_t   wr_data,
    input  logic    sr_set,
    input  logic    t1_set,
    input  logic    t2_set,
    output flg_t    flags,
    output flg_t    ena,
    output logic    irq
);
    flg_t clr_vec;
    flg_t set_vec;

    always_comb begin
        clr_vec = '0;
        if (strb.flag_wr)
            clr_vec = wr_data[FLG_W-1:0];
        if (strb.t1_hi_load || strb.t1_hi_only || strb.t1_rd_clr)
            clr_vec[FB_T1] = 1'b1;
        if (strb.t2_rd_clr)
            clr_vec[FB_T2] = 1'b1;
        set_vec         = '0;
        set_vec[FB_SR]  = sr_set;
        set_vec[FB_T1]  = t1_set;
        set_vec[FB_T2]  = t2_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            ena   <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
            if (strb.ena_wr) begin
                if (wr_data[SET_SEL])
                    ena <= ena | wr_data[FLG_W-1:0];
                else
                    ena <= ena & ~wr_data[FLG_W-1:0];
            end
        end
    end

    assign irq = |(flags & ena & IRQ_MASK);
endmodule

// File: rtl/vtm_timer_intc.sv
module vtm_timer_intc
    import vtm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       sr_event,
    input  logic [3:0] reg_idx,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq
);
    strobe_t strb;
    view_t   view;
    cnt_t    t1_cnt;
    cnt_t    t1_lat;
    cnt_t    t2_cnt;
    byte_t   aux_q;
    flg_t    flags;
    flg_t    ena;
    logic    t1_zero;
    logic    t2_zero;

    always_ff @(posedge clk) begin
        if (rst)
            aux_q <= '0;
        else if (strb.aux_wr)
            aux_q <= wr_data;
    end

    assign view = '{t1_cnt: t1_cnt, t1_lat: t1_lat, t2_cnt: t2_cnt,
                    aux: aux_q, flags: flags, ena: ena};

    vtm_regif u_regif (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .reg_idx (reg_idx),
        .view    (view),
        .strb    (strb),
        .rd_data (rd_data)
    );

    vtm_timer1 u_t1 (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .cont_mode (aux_q[DATA_W-1:DATA_W-2] == T1_CONTINUOUS),
        .lat_lo_wr (strb.t1_lat_lo),
        .hi_load   (strb.t1_hi_load),
        .hi_only   (strb.t1_hi_only),
        .wr_data   (wr_data),
        .cnt       (t1_cnt),
        .latch     (t1_lat),
        .zero_evt  (t1_zero)
    );

    vtm_timer2 u_t2 (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .lo_wr    (strb.t2_lo_wr),
        .hi_wr    (strb.t2_hi_wr),
        .wr_data  (wr_data),
        .cnt      (t2_cnt),
        .zero_evt (t2_zero)
    );

    vtm_intc u_intc (
        .clk     (clk),
        .rst     (rst),
        .strb    (strb),
        .wr_data (wr_data),
        .sr_set  (sr_event),
        .t1_set  (t1_zero),
        .t2_set  (t2_zero),
        .flags   (flags),
        .ena     (ena),
        .irq     (irq)
    );
endmodule

// File: rtl/vtm_checker.sv
module vtm_checker (
    input logic        clk,
    input logic        rst,
    input logic        tick_en,
    input logic        sr_event,
    input logic [3:0]  reg_idx,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic [7:0]  rd_data,
    input logic        irq,
    input logic [15:0] t1_cnt,
    input logic [6:0]  flags,
    input logic [7:0]  aux
);
    // R2: high-byte write loads counter top byte
    assert_t1_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == 4'd5) |=> (t1_cnt[15:8] == $past(wr_data)));

    // R3: index 7 write does not disturb the counter
    assert_t1_noload_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == 4'd7 && !tick_en) |=> $stable(t1_cnt));

    // R5: no timer-1 flag outside continuous mode
    assert_t1_mode_R5: assert property (@(posedge clk) disable iff (rst)
        (aux[7:6] != 2'b01) |=> !$rose(flags[6]));

    // R8: clearing all flags drops irq
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == 4'd13 && wr_data == 8'hFF && !sr_event && !tick_en) |=> !irq);

    // R9: enable register read has bit 7 set
    assert_ena_read_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_idx == 4'd14) |-> rd_data[7]);

    // R10: irq only from shift or timer-1 flag
    assert_irq_src_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags[2] || flags[6]));
endmodule

bind vtm_timer_intc vtm_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .sr_event (sr_event),
    .reg_idx  (reg_idx),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq      (irq),
    .t1_cnt   (t1_cnt),
    .flags    (flags),
    .aux      (aux_q)
);

// File: tb/vtm_timer_intc_tb.sv
module vtm_timer_intc_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       sr_event = 1'b0;
    logic [3:0] reg_idx = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vtm_timer_intc dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .sr_event(sr_event),
        .reg_idx(reg_idx), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [7:0] v);
        @(negedge clk);
        reg_idx = idx; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] idx, output logic [7:0] v);
        reg_idx = idx;
        #1 v = rd_data;
    endtask

    task automatic peek16(input logic [3:0] lo_idx, output logic [15:0] v);
        logic [7:0] l, h;
        peek(lo_idx, l);
        peek(lo_idx + 4'd1, h);
        v = {h, l};
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v; logic [15:0] w;
        peek16(4'd4, w); check("R1 t1 cnt", w, 16'hFFFF);
        peek16(4'd6, w); check("R1 t1 latch", w, 16'hFFFF);
        peek16(4'd8, w); check("R1 t2 cnt", w, 16'hFFFF);
        peek(4'd11, v); check("R1 aux", v, 8'h00);
        peek(4'd13, v); check("R1 flags", v, 8'h00);
        peek(4'd14, v); check("R1 enable", v, 8'h80);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_timer1();
        logic [7:0] v; logic [15:0] w;
        wr(4'd11, 8'h40);
        peek(4'd11, v); check("R5 aux readback", v, 8'h40);
        wr(4'd6, 8'h03);
        peek16(4'd6, w); check("R2 low latch via 6", w, 16'hFF03);
        wr(4'd5, 8'h00);
        peek16(4'd4, w); check("R2 load from latch", w, 16'h0003);
        tick(2);
        peek16(4'd4, w); check("R4 countdown", w, 16'h0001);
        peek(4'd13, v); check("R5 no flag yet", v, 8'h00);
        tick(1);
        peek16(4'd4, w); check("R4 at zero", w, 16'h0000);
        peek(4'd13, v); check("R5 flag at zero", v, 8'h40);
        tick(1);
        peek16(4'd4, w); check("R4 wrap", w, 16'hFFFF);
        tick(1);
        peek16(4'd4, w); check("R4 reload", w, 16'h0003);
        wr(4'd13, 8'h40);
        tick(3);
        peek(4'd13, v); check("R4 period latch+2", v, 8'h40);
        wr(4'd14, 8'hC0);
        peek(4'd14, v); check("R9 set enable", v, 8'hC0);
        check("R10 irq from t1", irq, 1);
        peek(4'd13, v); check("R8 pending bit", v, 8'hC0);
        wr(4'd7, 8'h12);
        peek(4'd7, v); check("R3 latch high", v, 8'h12);
        peek16(4'd4, w); check("R3 no load", w, 16'h0000);
        check("R3 flag cleared", irq, 0);
        tick(2);
        peek16(4'd4, w); check("R4 reload new latch", w, 16'h1203);
        wr(4'd4, 8'h01);
        wr(4'd5, 8'h00);
        tick(1);
        check("R5 flag again", irq, 1);
        peek(4'd5, v);
        @(negedge clk); reg_idx = 4'd5; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check("R6 read 5 keeps flag", irq, 1);
        rd(4'd4, v);
        check("R6 read 4 value", v, 8'h00);
        check("R6 read 4 clears", irq, 0);
    endtask

    task automatic t_mode();
        logic [7:0] v; logic [15:0] w;
        wr(4'd11, 8'hC0);
        wr(4'd6, 8'h01);
        wr(4'd5, 8'h00);
        tick(1);
        peek16(4'd4, w); check("R5 counts in other mode", w, 16'h0000);
        peek(4'd13, v); check("R5 no flag other mode", v, 8'h00);
        wr(4'd11, 8'h00);
        tick(3);
        peek(4'd13, v); check("R5 no flag mode 00", v, 8'h00);
    endtask

    task automatic t_timer2();
        logic [7:0] v; logic [15:0] w;
        wr(4'd8, 8'h02);
        peek16(4'd8, w); check("R7 t2 load low", w, 16'h0002);
        tick(1);
        peek(4'd13, v); check("R7 no flag yet", v, 8'h00);
        tick(1);
        peek16(4'd8, w); check("R7 t2 at zero", w, 16'h0000);
        peek(4'd13, v); check("R7 t2 flag", v, 8'h20);
        wr(4'd14, 8'hA0);
        peek(4'd13, v); check("R8 pending from t2", v, 8'hA0);
        check("R10 t2 no irq", irq, 0);
        tick(1);
        rd(4'd8, v);
        peek(4'd13, v); check("R7 read 8 clears", v, 8'h00);
        wr(4'd9, 8'h01);
        peek16(4'd8, w); check("R7 hi load", w, 16'h0102);
        tick(1);
        peek16(4'd8, w); check("R12 t2 tick", w, 16'h0101);
    endtask

    task automatic t_sr_and_ena();
        logic [7:0] v;
        wr(4'd14, 8'h84);
        @(negedge clk); sr_event = 1'b1;
        @(negedge clk); sr_event = 1'b0;
        check("R11 sr sets flag / R10 irq", irq, 1);
        peek(4'd13, v); check("R8 flag read", v, 8'h84);
        wr(4'd13, 8'h04);
        check("R8 write clears", irq, 0);
        @(negedge clk);
        reg_idx = 4'd13; wr_data = 8'hFF; wr_en = 1'b1; sr_event = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sr_event = 1'b0;
        check("R11 set wins", irq, 1);
        wr(4'd14, 8'h04);
        check("R9 clear enable drops irq", irq, 0);
        peek(4'd14, v); check("R9 enable readback", v, 8'hE0);
        wr(4'd13, 8'hFF);
    endtask

    task automatic t_tick_gate();
        logic [15:0] w0, w1;
        peek16(4'd4, w0);
        repeat (5) @(negedge clk);
        peek16(4'd4, w1); check("R12 no tick no change", w1, w0);
        @(negedge clk);
        reg_idx = 4'd5; wr_data = 8'h00; wr_en = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        peek16(4'd4, w1); check("R12 load beats tick", w1, 16'h0001);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_timer1();
        t_mode();
        t_timer2();
        t_sr_and_ena();
        t_tick_gate();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule